// File: doc/BRIEF.md
# Error-Compensated Parallel Adder Tree

This block adds Q signed partial-product words in one pass of combinational logic and registers a P-bit result. Word j carries a weight of 2^-j, so each word sits one bit further right than the one before it. Only the columns at or above the weight of word 0's least significant bit are kept. The bits that fall below that point form a truncation region. Dropping them outright would bias every result downwards. Instead, the block counts the ones on the first DIAG diagonals of that region, weights each diagonal by its column weight, and rounds the total. It adds the rounded bias into the least significant kept column.

The words arrive packed on one bus. Each word is P-1 bits wide, two's complement, and word j occupies bits [j*(P-1) +: P-1]. Because the words are one bit narrower than the result, the weighted sum always fits in P bits. All Q word operands and the bias operand pass through a chain of full-adder carry-save rows. A final carry-propagate adder, built from one half-adder cell and full-adder cells, resolves the result. A parameter selects either the compensated variant or a plain-truncation variant. The result register loads only on cycles that carry a valid input, and the valid flag travels alongside the result.

Top module: `ecat_tree`

## Requirements
- R1: While rst_n is low, valid_o reads 0 and sum_o reads 0.
- R2: valid_o equals the valid_i value sampled at the previous rising clock edge, so the latency is exactly one cycle.
- R3: Word j is the two's complement value in words_i[j*(P-1) +: P-1]. After a valid input, sum_o (two's complement, P bits) equals MP + bias. MP is the sum over j of floor(word_j / 2^j), which is an arithmetic right shift by j.
- R4: With compensation enabled, bias = floor(1/2 + sum for c=1..DIAG of n_c * 2^-c). Here n_c counts the ones among bit (j-c) of word j for j = c..Q-1. With defaults (P=12, Q=9, DIAG=3): word 1 = 1 gives 1, word 2 = 1 gives 0, word 3 = 7 gives 1, and all words = -1 give -2.
- R5: The result never wraps. With defaults, all words at +1023 give 2042 and all words at -1024 give -2044. A non-negative word set gives a non-negative sum, and an all-negative word set gives a negative sum.
- R6: On a cycle with valid_i low, sum_o keeps its previous value whatever words_i carries.
- R7: With COMPENSATE=0 the bias is zero and sum_o equals MP. With defaults, all words = -1 give -9 and all words = +1023 give 2035.
- R8: With DIAG = Q-1, sum_o equals the exact weighted sum rounded to the nearest integer, with halves rounded upwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Marks words_i as carrying a word set to be summed |
| words_i | input | Q*(P-1) | Q packed two's complement words, word 0 in the low bits |
| valid_o | output | 1 | valid_i delayed by one cycle |
| sum_o | output | P | Compensated, weighted sum of the last valid word set |

## Verification
All three variants (partial-depth compensation, full-depth compensation and plain truncation) share one stimulus stream. A single vector therefore separates the bias logic from the main-part adder. Saturated words of both signs, all-ones and alternating patterns stress the sign extension and the carry-save chain. Single-word vectors with one to three low bits set probe one diagonal at a time, which shows whether each column's weight and the rounding half are correct. A long pseudo-random run checks the full-depth variant against the exact sum rounded to the nearest integer, and accumulates the mean and largest absolute error of the default and truncating variants against the exact value.

// File: rtl/ecat_pkg.sv
package ecat_pkg;

   // width of the bias accumulator: holds up to 2*Q-1 before halving
   function automatic int bias_width(input int q);
      return $clog2(q) + 2;
   endfunction

   // width of one input word for a P-bit result
   function automatic int word_width(input int p);
      return p - 1;
   endfunction

endpackage

// File: rtl/ecat_fa.sv
module ecat_fa (
   input  logic a_i,
   input  logic b_i,
   input  logic c_i,
   output logic s_o,
   output logic co_o
);
   assign s_o  = a_i ^ b_i ^ c_i;
   assign co_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/ecat_ha.sv
module ecat_ha (
   input  logic a_i,
   input  logic b_i,
   output logic s_o,
   output logic co_o
);
   assign s_o  = a_i ^ b_i;
   assign co_o = a_i & b_i;
endmodule

// File: rtl/ecat_csa_row.sv
// One carry-save row: three operands in, sum and shifted carry out (mod 2^WIDTH).
module ecat_csa_row #(
   parameter int unsigned WIDTH = 12
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] sum_o,
   output logic [WIDTH-1:0] carry_o
);
   logic [WIDTH-2:0] maj;

   for (genvar b = 0; b < WIDTH - 1; b++) begin : g_cell
      ecat_fa u_fa (
         .a_i  (a_i[b]),
         .b_i  (b_i[b]),
         .c_i  (d_i[b]),
         .s_o  (sum_o[b]),
         .co_o (maj[b])
      );
   end

   // the top column's carry would leave the word, so only its sum is formed
   assign sum_o[WIDTH-1] = a_i[WIDTH-1] ^ b_i[WIDTH-1] ^ d_i[WIDTH-1];
   assign carry_o        = {maj, 1'b0};
endmodule

// File: rtl/ecat_cpa.sv
// Ripple carry-propagate adder, half-adder at bit 0, result mod 2^WIDTH.
module ecat_cpa #(
   parameter int unsigned WIDTH = 12
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   output logic [WIDTH-1:0] sum_o
);
   logic [WIDTH-1:1] cy;

   ecat_ha u_ha0 (
      .a_i  (a_i[0]),
      .b_i  (b_i[0]),
      .s_o  (sum_o[0]),
      .co_o (cy[1])
   );

   for (genvar b = 1; b < WIDTH - 1; b++) begin : g_bit
      ecat_fa u_fa (
         .a_i  (a_i[b]),
         .b_i  (b_i[b]),
         .c_i  (cy[b]),
         .s_o  (sum_o[b]),
         .co_o (cy[b+1])
      );
   end

   assign sum_o[WIDTH-1] = a_i[WIDTH-1] ^ b_i[WIDTH-1] ^ cy[WIDTH-1];
endmodule

// File: rtl/ecat_bias.sv
// Rounded compensation bias from the first DIAG diagonals below the kept columns.
// Columns are folded from the deepest upwards; each fold halves with floor,
// which composes to the floor of the whole weighted sum.
module ecat_bias
   import ecat_pkg::*;
#(
   parameter int unsigned Q    = 9,
   parameter int unsigned W    = 11,
   parameter int unsigned DIAG = 3,
   localparam int unsigned BW  = bias_width(Q)
) (
   input  logic [Q*W-1:0] words_i,
   output logic [BW-1:0]  bias_o
);
   logic [BW-1:0] acc;

   always_comb begin
      acc = '0;
      for (int c = DIAG; c >= 1; c--) begin
         for (int j = c; j < Q; j++) begin
            acc = acc + BW'(words_i[j*W + j - c]);
         end
         // the rounding half enters at the column of weight 1/2
         acc = acc + BW'(c == 1);
         acc = acc >> 1;
      end
   end

   assign bias_o = acc;
endmodule

// File: rtl/ecat_tree.sv
module ecat_tree
   import ecat_pkg::*;
#(
   parameter int unsigned P          = 12,
   parameter int unsigned Q          = 9,
   parameter int unsigned DIAG       = 3,
   parameter bit          COMPENSATE = 1'b1,
   localparam int unsigned W         = word_width(P),
   localparam int unsigned BW        = bias_width(Q),
   localparam int unsigned N         = Q + 1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           valid_i,
   input  logic [Q*W-1:0] words_i,
   output logic           valid_o,
   output logic [P-1:0]   sum_o
);
   // ---------------- elaboration-time parameter checks ----------------
   if (P < 4) begin : g_bad_p
      $error("ecat_tree: P must be at least 4");
   end
   if (Q < 2 || Q > P) begin : g_bad_q
      $error("ecat_tree: Q must lie between 2 and P");
   end
   if (DIAG < 1 || DIAG > Q - 1) begin : g_bad_diag
      $error("ecat_tree: DIAG must lie between 1 and Q-1");
   end

   // ---------------- aligned operands ----------------
   logic [P-1:0] op [N];
   logic [Q-1:0] signs;
   logic [BW-1:0] bias;

   for (genvar j = 0; j < Q; j++) begin : g_word
      logic signed [W-1:0] wj;
      assign wj       = words_i[j*W +: W];
      assign signs[j] = wj[W-1];
      // floor(word / 2^j), sign-extended by one bit to the result width
      assign op[j]    = {wj[W-1], wj >>> j};
   end

   if (COMPENSATE) begin : g_comp
      ecat_bias #(
         .Q    (Q),
         .W    (W),
         .DIAG (DIAG)
      ) u_bias (
         .words_i (words_i),
         .bias_o  (bias)
      );

      assert_bias_bound_R4 : assert property (
         @(posedge clk) disable iff (!rst_n)
         valid_i |-> (int'(bias) <= int'(Q) - 1)
      ) else $error("bias exceeds Q-1");
   end else begin : g_trunc
      assign bias = '0;
   end

   assign op[Q] = P'(bias);

   // ---------------- carry-save chain ----------------
   logic [P-1:0] st_s [1:N-1];
   logic [P-1:0] st_c [1:N-1];
   logic [P-1:0] fin;

   assign st_s[1] = op[0];
   assign st_c[1] = op[1];

   for (genvar k = 2; k < N; k++) begin : g_row
      ecat_csa_row #(
         .WIDTH (P)
      ) u_row (
         .a_i     (st_s[k-1]),
         .b_i     (st_c[k-1]),
         .d_i     (op[k]),
         .sum_o   (st_s[k]),
         .carry_o (st_c[k])
      );
   end

   ecat_cpa #(
      .WIDTH (P)
   ) u_cpa (
      .a_i   (st_s[N-1]),
      .b_i   (st_c[N-1]),
      .sum_o (fin)
   );

   // ---------------- output register ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         sum_o   <= '0;
      end else begin
         valid_o <= valid_i;
         if (valid_i) begin
            sum_o <= fin;
         end
      end
   end

   // ---------------- assertions ----------------
   assert_valid_delay_R2 : assert property (
      @(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (valid_o == $past(valid_i))
   ) else $error("valid_o does not follow valid_i by one cycle");

   assert_hold_R6 : assert property (
      @(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(valid_i)) |-> $stable(sum_o)
   ) else $error("sum_o changed without a valid input");

   assert_no_overflow_R5 : assert property (
      @(posedge clk) disable iff (!rst_n)
      (valid_i && (signs == '0)) |-> !fin[P-1]
   ) else $error("non-negative words produced a negative sum");

   assert_no_underflow_R5 : assert property (
      @(posedge clk) disable iff (!rst_n)
      (valid_i && (&signs)) |-> fin[P-1]
   ) else $error("negative words produced a non-negative sum");

endmodule

// File: tb/test_ecat_tree.sv
module test_ecat_tree;
   localparam int P  = 12;
   localparam int Q  = 9;
   localparam int D  = 3;
   localparam int W  = P - 1;
   localparam int QW = Q * W;

   localparam logic [QW-1:0] TABLE [6] = '{
      {Q{11'h3FF}},
      {Q{11'h400}},
      {Q{11'h7FF}},
      {QW{1'b0}},
      {Q{11'h555}},
      {Q{11'h2AA}}
   };

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n;
   logic          valid_i;
   logic [QW-1:0] words_i;
   logic          valid_c, valid_t, valid_f;
   logic [P-1:0]  sum_c, sum_t, sum_f;

   ecat_tree #(.P(P), .Q(Q), .DIAG(D), .COMPENSATE(1'b1)) i_ecat_tree (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .words_i(words_i),
      .valid_o(valid_c), .sum_o(sum_c));

   ecat_tree #(.P(P), .Q(Q), .DIAG(D), .COMPENSATE(1'b0)) i_ecat_trunc (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .words_i(words_i),
      .valid_o(valid_t), .sum_o(sum_t));

   ecat_tree #(.P(P), .Q(Q), .DIAG(Q-1), .COMPENSATE(1'b1)) i_ecat_full (
      .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .words_i(words_i),
      .valid_o(valid_f), .sum_o(sum_f));

   int checks   = 0;
   int failures = 0;
   bit done     = 1'b0;
   real err_sum_c = 0.0, err_max_c = 0.0, err_sum_t = 0.0, err_max_t = 0.0;
   int  n_err = 0;
   int unsigned seed = 32'h1234_5678;

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int word(input logic [QW-1:0] v, input int j);
      logic signed [W-1:0] w;
      w = v[j*W +: W];
      return int'(w);
   endfunction

   function automatic int model_mp(input logic [QW-1:0] v);
      int s = 0;
      for (int j = 0; j < Q; j++) s += word(v, j) >>> j;
      return s;
   endfunction

   function automatic int model_bias(input logic [QW-1:0] v, input int d);
      int num = 0;
      for (int c = 1; c <= d; c++)
         for (int j = c; j < Q; j++)
            if (v[j*W + j - c]) num += 1 << (d - c);
      return (num + (1 << (d - 1))) >>> d;
   endfunction

   function automatic longint model_exact(input logic [QW-1:0] v);
      longint e = 0;
      for (int j = 0; j < Q; j++) e += longint'(word(v, j)) <<< (Q - 1 - j);
      return e;
   endfunction

   function automatic int sval(input logic [P-1:0] x);
      logic signed [P-1:0] s;
      s = x;
      return int'(s);
   endfunction

   function automatic real absr(input real x);
      return (x < 0.0) ? -x : x;
   endfunction

   task automatic drive(input logic [QW-1:0] v, input logic vld);
      @(negedge clk);
      words_i = v;
      valid_i = vld;
      @(negedge clk);
   endtask

   // one valid vector through all three variants, checked against the models
   task automatic run_vec(input logic [QW-1:0] v);
      longint e;
      real exact, ec, et;
      drive(v, 1'b1);
      e = model_exact(v);
      chk("R2 valid_o after valid input", int'(valid_c), 1);
      chk("R3 R4 compensated sum", sval(sum_c), model_mp(v) + model_bias(v, D));
      chk("R7 truncating sum", sval(sum_t), model_mp(v));
      chk("R8 full-depth rounded sum", sval(sum_f),
          int'((e + (longint'(1) <<< (Q - 2))) >>> (Q - 1)));
      exact = real'(e) / real'(longint'(1) <<< (Q - 1));
      ec = absr(real'(sval(sum_c)) - exact);
      et = absr(real'(sval(sum_t)) - exact);
      err_sum_c += ec;
      err_sum_t += et;
      if (ec > err_max_c) err_max_c = ec;
      if (et > err_max_t) err_max_t = et;
      n_err++;
   endtask

   function automatic logic [QW-1:0] next_vec();
      logic [QW-1:0] v;
      for (int j = 0; j < Q; j++) begin
         seed = seed * 32'd1664525 + 32'd1013904223;
         v[j*W +: W] = W'(seed >> 9);
      end
      return v;
   endfunction

   function automatic logic [QW-1:0] single(input int j, input int val);
      logic [QW-1:0] v = '0;
      v[j*W +: W] = W'(val);
      return v;
   endfunction

   initial begin
      logic [QW-1:0] va, vb;
      int hold_exp;
      rst_n   = 1'b0;
      valid_i = 1'b0;
      words_i = '0;

      // R1: reset state with active-looking inputs
      @(negedge clk);
      valid_i = 1'b1;
      words_i = TABLE[0];
      repeat (2) @(negedge clk);
      chk("R1 valid_o in reset", int'(valid_c), 0);
      chk("R1 sum_o in reset", sval(sum_c), 0);
      chk("R1 truncating sum_o in reset", sval(sum_t), 0);
      valid_i = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;

      foreach (TABLE[i]) run_vec(TABLE[i]);
      for (int i = 0; i < 400; i++) run_vec(next_vec());

      // R5: extremes
      drive({Q{11'h3FF}}, 1'b1);
      chk("R5 all max words", sval(sum_c), 2042);
      chk("R7 all max words truncated", sval(sum_t), 2035);
      drive({Q{11'h400}}, 1'b1);
      chk("R5 all min words", sval(sum_c), -2044);

      // R4: single diagonals and all ones
      drive(single(1, 1), 1'b1);
      chk("R4 word1=1", sval(sum_c), 1);
      drive(single(2, 1), 1'b1);
      chk("R4 word2=1", sval(sum_c), 0);
      drive(single(3, 7), 1'b1);
      chk("R4 word3=7", sval(sum_c), 1);
      drive({Q{11'h7FF}}, 1'b1);
      chk("R4 all words -1", sval(sum_c), -2);
      chk("R7 all words -1 truncated", sval(sum_t), -9);
      chk("R8 all words -1 full depth", sval(sum_f), -2);
      drive(single(1, 1), 1'b1);
      chk("R8 word1=1 rounds half up", sval(sum_f), 1);

      // R6 / R2: hold while invalid
      va = {Q{11'h155}};
      vb = {Q{11'h2AA}};
      drive(va, 1'b1);
      hold_exp = model_mp(va) + model_bias(va, D);
      chk("R3 hold setup", sval(sum_c), hold_exp);
      drive(vb, 1'b0);
      chk("R6 sum held with valid low", sval(sum_c), hold_exp);
      chk("R2 valid_o low after invalid", int'(valid_c), 0);
      drive(next_vec(), 1'b0);
      chk("R6 sum held second cycle", sval(sum_c), hold_exp);
      chk("R6 truncating sum held", sval(sum_t), model_mp(va));
      drive(vb, 1'b1);
      chk("R6 update after valid returns", sval(sum_c), model_mp(vb) + model_bias(vb, D));
      chk("R2 valid_o high again", int'(valid_c), 1);

      $display("stats compensated mean_abs=%f max_abs=%f",
               err_sum_c / real'(n_err), err_max_c);
      $display("stats truncated   mean_abs=%f max_abs=%f",
               err_sum_t / real'(n_err), err_max_t);
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule